// File: doc/BRIEF.md
# Cluster Bring-up and Occupancy Tracker

This block takes boot requests for individual cores in a two-cluster machine with four cores per cluster. For each core it keeps an online count. When a request names a core whose cluster has no core online, the block first powers the cluster up. It runs a fixed series of one-cycle steps on the cluster's control lines, then hands the core over to a separate core sequencer through a start pulse. When the request names a core in a cluster that is already running, the block skips the cluster steps and starts the core sequencer directly. A request for a core that is already online only raises that core's count.

The cluster bring-up works as follows. It first raises the coherency-quiesce line, which keeps the cluster's interconnect port idle. Next it puts all four cores into power-on reset hold. It then asserts the cluster and debug resets, and also the trace resets if the cluster is of the little type. After that it pulls the reset-disable lines low and opens the cluster power gate. It then waits a settling time of WAIT_CYCLES clocks, which is 20 µs at 100 MHz. Finally it releases the three cluster-level resets and drops the quiesce line. The block takes one request at a time and reports completion with a one-cycle done pulse.

Top module: `cluster_bringup_ctl`

## Requirements
- R1: A request with cluster index of 2 or more, or core index of 4 or more, is rejected. The done pulse comes with done_err=1, there is no start pulse and no cluster line moves, and the online mask is unchanged.
- R2: A request for a core whose online bit is already 1 ends with done (done_err=0). It gives no start pulse and no quiesce activity.
- R3: If all four online bits of the target cluster are 0, first_comer becomes 1 and the cluster bring-up runs before the core start. Otherwise first_comer becomes 0 and the start pulse follows acceptance directly.
- R4: Bring-up order is one step per cycle: quiesce[c] rises; then the four por_hold bits of cluster c rise; then dbgsoc_rst[c], hub_rst[c], l2_rst[c] and the four dbg_hold bits rise, together with the four trc_hold bits only when req_little=1.
- R5: In the next cycle l2_rst_dis[c] goes low. For a little cluster the four l1_rst_dis bits also go low; for a big cluster they stay high. In the cycle after that, pwr_gate[c] goes low (1 = gated off).
- R6: dbgsoc_rst[c], hub_rst[c] and l2_rst[c] are released exactly WAIT_CYCLES+1 cycles after pwr_gate[c] falls. quiesce[c] falls one cycle after that, and quiesce stays high over the gate opening and the release.
- R7: core_start is a one-cycle pulse. It carries tgt_cluster/tgt_core and arrives one cycle after quiesce falls, or one cycle after acceptance for a running cluster. It clears that core's por_hold, dbg_hold and trc_hold bits. done follows core_done.
- R8: ready drops at acceptance and returns after the done pulse. After a successful done, online bit cluster*4+core is 1.
- R9: After reset, only online bit 0 is set (boot core: cluster 0, core 0), pwr_gate=2'b10, all reset and hold outputs are 0, the reset-disable lines are 1, quiesce is 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Boot request, taken when ready is high |
| req_cluster | input | 2 | Requested cluster index |
| req_core | input | 3 | Requested core index |
| req_little | input | 1 | Target cluster is of the little type |
| ready | output | 1 | Idle, able to accept a request |
| core_done | input | 1 | Core sequencer finished |
| core_start | output | 1 | Start pulse to the core sequencer |
| tgt_cluster | output | 1 | Cluster of the core being started |
| tgt_core | output | 2 | Core being started |
| first_comer | output | 1 | Last accepted request powered up its cluster |
| done | output | 1 | Request completion pulse |
| done_err | output | 1 | Qualifies done: request rejected |
| online | output | 8 | Core online mask, bit cluster*4+core |
| quiesce | output | 2 | Per-cluster coherency-port quiesce |
| dbgsoc_rst | output | 2 | Per-cluster debug-SoC reset, active high |
| hub_rst | output | 2 | Per-cluster hub reset, active high |
| l2_rst | output | 2 | Per-cluster L2 reset, active high |
| pwr_gate | output | 2 | Per-cluster power gate, 1 = gated |
| l2_rst_dis | output | 2 | Per-cluster L2 reset-disable line |
| por_hold | output | 8 | Per-core power-on reset hold |
| dbg_hold | output | 8 | Per-core debug reset hold |
| trc_hold | output | 8 | Per-core trace reset hold |
| l1_rst_dis | output | 8 | Per-core L1 reset-disable line |

## Verification
Each bring-up step shows on its output one cycle after the previous step. The quiesce line shows one cycle after acceptance, and the release shows WAIT_CYCLES+1 cycles after the gate opens. The bench samples every output at each falling edge from acceptance to done and records the cycle in which each step first appears. It then checks the exact spacing of those recorded cycles rather than checking at fixed times. The online mask is read in the cycle after done, because the count changes on the edge that ends the done pulse.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_QUIESCE, ST_CORE_POR, ST_CL_RST, ST_RSTDIS, ST_UNGATE,
    ST_SETTLE, ST_RELEASE, ST_UNQUIESCE, ST_START, ST_WAIT_CORE, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cbt_occupancy.sv
module cbt_occupancy #(
  parameter int NCL     = 2,
  parameter int NCO     = 4,
  parameter int CNT_W   = 4,
  parameter int BOOT_CL = 0,
  parameter int BOOT_CO = 0,
  localparam int CL_W   = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int CO_W   = (NCO > 1) ? $clog2(NCO) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic [CL_W-1:0]      inc_cl,
  input  logic [CO_W-1:0]      inc_co,
  output logic [NCL*NCO-1:0]   online,
  output logic [NCL-1:0]       cluster_down
);
  localparam int NSLOT = NCL * NCO;
  localparam int BOOT_IDX = BOOT_CL * NCO + BOOT_CO;

  int sel;
  assign sel = int'(inc_cl) * NCO + int'(inc_co);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [CNT_W-1:0] cnt_q, cnt_d;
    always_comb begin
      cnt_d = cnt_q;
      if (inc && (sel == i) && (cnt_q != '1)) cnt_d = cnt_q + CNT_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= (i == BOOT_IDX) ? CNT_W'(1) : '0;
      else        cnt_q <= cnt_d;
    end
    assign online[i] = |cnt_q;
    // R8: an online core never drops out
    a_r8_stays_online: assert property (@(posedge clk) disable iff (!rst_n)
      online[i] |=> online[i]);
  end

  for (genvar c = 0; c < NCL; c++) begin : g_down
    assign cluster_down[c] = ~|online[c*NCO +: NCO];
  end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import cbt_pkg::*;
#(
  parameter int NCL         = 2,
  parameter int NCO         = 4,
  parameter int WAIT_CYCLES = 2000,
  localparam int CL_W       = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int CO_W       = (NCO > 1) ? $clog2(NCO) : 1,
  localparam int RCL_W      = $clog2(NCL) + 1,
  localparam int RCO_W      = $clog2(NCO) + 1,
  localparam int N          = NCL * NCO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [RCL_W-1:0]  req_cluster,
  input  logic [RCO_W-1:0]  req_core,
  input  logic              req_little,
  input  logic              core_done,
  input  logic [N-1:0]      online,
  input  logic [NCL-1:0]    cluster_down,
  output logic              ready,
  output logic              done,
  output logic              done_err,
  output logic              first_comer,
  output logic              core_start,
  output logic [CL_W-1:0]   tgt_cluster,
  output logic [CO_W-1:0]   tgt_core,
  output logic              inc,
  output logic [NCL-1:0]    quiesce,
  output logic [NCL-1:0]    dbgsoc_rst,
  output logic [NCL-1:0]    hub_rst,
  output logic [NCL-1:0]    l2_rst,
  output logic [NCL-1:0]    pwr_gate,
  output logic [NCL-1:0]    l2_rst_dis,
  output logic [N-1:0]      por_hold,
  output logic [N-1:0]      dbg_hold,
  output logic [N-1:0]      trc_hold,
  output logic [N-1:0]      l1_rst_dis
);
  localparam int TM_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [RCL_W-1:0] NCL_V = RCL_W'(NCL);
  localparam logic [RCO_W-1:0] NCO_V = RCO_W'(NCO);

  seq_state_e state_q, state_d;
  logic [CL_W-1:0] cl_q, cl_d;
  logic [CO_W-1:0] co_q, co_d;
  logic little_q, little_d, err_q, err_d, first_q, first_d, start_q, start_d;
  logic [TM_W-1:0] timer_q, timer_d;
  logic [NCL-1:0] qui_q, qui_d, dsr_q, dsr_d, hub_q, hub_d, l2_q, l2_d;
  logic [NCL-1:0] gate_q, gate_d, l2dis_q, l2dis_d;
  logic [N-1:0] por_q, por_d, dbg_q, dbg_d, trc_q, trc_d, l1dis_q, l1dis_d;

  logic [CL_W-1:0] rcl;
  logic [CO_W-1:0] rco;
  logic req_ok;
  int req_idx, base;
  assign rcl     = req_cluster[CL_W-1:0];
  assign rco     = req_core[CO_W-1:0];
  assign req_ok  = (req_cluster < NCL_V) && (req_core < NCO_V);
  assign req_idx = int'(rcl) * NCO + int'(rco);
  assign base    = int'(cl_q) * NCO;

  always_comb begin
    state_d = state_q; cl_d = cl_q; co_d = co_q; little_d = little_q;
    err_d = err_q; first_d = first_q; start_d = 1'b0; timer_d = timer_q;
    qui_d = qui_q; dsr_d = dsr_q; hub_d = hub_q; l2_d = l2_q;
    gate_d = gate_q; l2dis_d = l2dis_q;
    por_d = por_q; dbg_d = dbg_q; trc_d = trc_q; l1dis_d = l1dis_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        cl_d = rcl; co_d = rco; little_d = req_little; err_d = !req_ok;
        if (!req_ok || online[req_idx]) state_d = ST_DONE;
        else if (cluster_down[rcl]) begin first_d = 1'b1; state_d = ST_QUIESCE; end
        else begin first_d = 1'b0; state_d = ST_START; end
      end
      ST_QUIESCE:  begin qui_d[cl_q] = 1'b1; state_d = ST_CORE_POR; end
      ST_CORE_POR: begin por_d[base +: NCO] = '1; state_d = ST_CL_RST; end
      ST_CL_RST: begin
        dsr_d[cl_q] = 1'b1; hub_d[cl_q] = 1'b1; l2_d[cl_q] = 1'b1;
        dbg_d[base +: NCO] = '1;
        if (little_q) trc_d[base +: NCO] = '1;
        state_d = ST_RSTDIS;
      end
      ST_RSTDIS: begin
        l2dis_d[cl_q] = 1'b0;
        if (little_q) l1dis_d[base +: NCO] = '0;
        state_d = ST_UNGATE;
      end
      ST_UNGATE: begin
        gate_d[cl_q] = 1'b0; timer_d = TM_W'(WAIT_CYCLES - 1); state_d = ST_SETTLE;
      end
      ST_SETTLE: if (timer_q == '0) state_d = ST_RELEASE;
                 else timer_d = timer_q - TM_W'(1);
      ST_RELEASE: begin
        dsr_d[cl_q] = 1'b0; hub_d[cl_q] = 1'b0; l2_d[cl_q] = 1'b0;
        state_d = ST_UNQUIESCE;
      end
      ST_UNQUIESCE: begin qui_d[cl_q] = 1'b0; state_d = ST_START; end
      ST_START: begin
        start_d = 1'b1;
        por_d[base + int'(co_q)] = 1'b0;
        dbg_d[base + int'(co_q)] = 1'b0;
        trc_d[base + int'(co_q)] = 1'b0;
        state_d = ST_WAIT_CORE;
      end
      ST_WAIT_CORE: if (core_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cl_q <= '0; co_q <= '0; little_q <= 1'b0;
      err_q <= 1'b0; first_q <= 1'b0; start_q <= 1'b0; timer_q <= '0;
      qui_q <= '0; dsr_q <= '0; hub_q <= '0; l2_q <= '0;
      gate_q <= ~(NCL'(1) << 0); l2dis_q <= '1;
      por_q <= '0; dbg_q <= '0; trc_q <= '0; l1dis_q <= '1;
    end else begin
      state_q <= state_d; cl_q <= cl_d; co_q <= co_d; little_q <= little_d;
      err_q <= err_d; first_q <= first_d; start_q <= start_d; timer_q <= timer_d;
      qui_q <= qui_d; dsr_q <= dsr_d; hub_q <= hub_d; l2_q <= l2_d;
      gate_q <= gate_d; l2dis_q <= l2dis_d;
      por_q <= por_d; dbg_q <= dbg_d; trc_q <= trc_d; l1dis_q <= l1dis_d;
    end
  end

  assign ready = (state_q == ST_IDLE);
  assign done = (state_q == ST_DONE);
  assign done_err = done && err_q;
  assign inc = done && !err_q;
  assign first_comer = first_q;
  assign core_start = start_q;
  assign tgt_cluster = cl_q;
  assign tgt_core = co_q;
  assign quiesce = qui_q; assign dbgsoc_rst = dsr_q; assign hub_rst = hub_q;
  assign l2_rst = l2_q; assign pwr_gate = gate_q; assign l2_rst_dis = l2dis_q;
  assign por_hold = por_q; assign dbg_hold = dbg_q; assign trc_hold = trc_q;
  assign l1_rst_dis = l1dis_q;

  // R7: start is a single-cycle pulse
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R8: no start while idle
  a_r8_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !ready);
  // R1: a rejected request leaves the online mask alone
  a_r1_reject_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> online == $past(online));

  for (genvar c = 0; c < NCL; c++) begin : g_chk
    // R3: bring-up only starts on a cluster with no core online
    a_r3_quiesce_needs_down: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(quiesce[c]) |-> cluster_down[c]);
    // R4: the gate opens only with the cluster resets held
    a_r4_gate_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_gate[c]) |-> (l2_rst[c] && hub_rst[c] && dbgsoc_rst[c]));
    // R5: the gate opens only while quiesced
    a_r5_gate_under_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_gate[c]) |-> quiesce[c]);
    // R6: reset release happens while still quiesced
    a_r6_release_under_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l2_rst[c]) |-> quiesce[c]);
  end
endmodule

// File: rtl/cluster_bringup_ctl.sv
module cluster_bringup_ctl #(
  parameter int N_CLUSTERS  = 2,
  parameter int N_CORES     = 4,
  parameter int CNT_W       = 4,
  parameter int WAIT_CYCLES = 2000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [$clog2(N_CLUSTERS):0]       req_cluster,
  input  logic [$clog2(N_CORES):0]          req_core,
  input  logic                              req_little,
  output logic                              ready,
  input  logic                              core_done,
  output logic                              core_start,
  output logic [$clog2(N_CLUSTERS)-1:0]     tgt_cluster,
  output logic [$clog2(N_CORES)-1:0]        tgt_core,
  output logic                              first_comer,
  output logic                              done,
  output logic                              done_err,
  output logic [N_CLUSTERS*N_CORES-1:0]     online,
  output logic [N_CLUSTERS-1:0]             quiesce,
  output logic [N_CLUSTERS-1:0]             dbgsoc_rst,
  output logic [N_CLUSTERS-1:0]             hub_rst,
  output logic [N_CLUSTERS-1:0]             l2_rst,
  output logic [N_CLUSTERS-1:0]             pwr_gate,
  output logic [N_CLUSTERS-1:0]             l2_rst_dis,
  output logic [N_CLUSTERS*N_CORES-1:0]     por_hold,
  output logic [N_CLUSTERS*N_CORES-1:0]     dbg_hold,
  output logic [N_CLUSTERS*N_CORES-1:0]     trc_hold,
  output logic [N_CLUSTERS*N_CORES-1:0]     l1_rst_dis
);
  logic inc;
  logic [N_CLUSTERS-1:0] cluster_down;

  cbt_occupancy #(.NCL(N_CLUSTERS), .NCO(N_CORES), .CNT_W(CNT_W),
                  .BOOT_CL(0), .BOOT_CO(0)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(inc), .inc_cl(tgt_cluster),
    .inc_co(tgt_core), .online(online), .cluster_down(cluster_down));

  cbt_seq #(.NCL(N_CLUSTERS), .NCO(N_CORES), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cluster(req_cluster),
    .req_core(req_core), .req_little(req_little), .core_done(core_done),
    .online(online), .cluster_down(cluster_down), .ready(ready), .done(done),
    .done_err(done_err), .first_comer(first_comer), .core_start(core_start),
    .tgt_cluster(tgt_cluster), .tgt_core(tgt_core), .inc(inc),
    .quiesce(quiesce), .dbgsoc_rst(dbgsoc_rst), .hub_rst(hub_rst),
    .l2_rst(l2_rst), .pwr_gate(pwr_gate), .l2_rst_dis(l2_rst_dis),
    .por_hold(por_hold), .dbg_hold(dbg_hold), .trc_hold(trc_hold),
    .l1_rst_dis(l1_rst_dis));
endmodule

// File: tb/sim_cluster_bringup_ctl.sv
`timescale 1ns/1ps
module sim_cluster_bringup_ctl;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_little = 1'b0, core_done = 1'b0;
  logic [1:0] req_cluster = '0;
  logic [2:0] req_core = '0;
  logic ready, core_start, first_comer, done, done_err;
  logic [0:0] tgt_cluster;
  logic [1:0] tgt_core;
  logic [7:0] online, por_hold, dbg_hold, trc_hold, l1_rst_dis;
  logic [1:0] quiesce, dbgsoc_rst, hub_rst, l2_rst, pwr_gate, l2_rst_dis;

  cluster_bringup_ctl #(.WAIT_CYCLES(W)) u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, cd_cnt = 0;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    core_done = (cd_cnt == 1);
    if (core_start) cd_cnt = 3;
    else if (cd_cnt > 0) cd_cnt--;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  int tq, tp, tr, td, tg, trl, tu, ts, nstart, busy_bad, fc, err, trc_at, l1_at;
  logic [7:0] on_before, on_after;

  task automatic do_req(input int cl, input int co, input bit lt);
    tq = -1; tp = -1; tr = -1; td = -1; tg = -1; trl = -1; tu = -1; ts = -1;
    nstart = 0; busy_bad = 0; trc_at = -1; l1_at = -1;
    on_before = online;
    @(negedge clk);
    req_valid = 1'b1; req_cluster = 2'(cl); req_core = 3'(co); req_little = lt;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (k > 0) @(negedge clk);
      if (ready) busy_bad++;
      if (cl < 2) begin
        if (quiesce[cl] && tq < 0) tq = k;
        if (por_hold[cl*4 +: 4] == 4'hF && tp < 0) tp = k;
        if (hub_rst[cl] && tr < 0) begin tr = k; trc_at = trc_hold[cl*4 +: 4]; end
        if (!l2_rst_dis[cl] && td < 0) begin td = k; l1_at = l1_rst_dis[cl*4 +: 4]; end
        if (!pwr_gate[cl] && tg < 0) tg = k;
        if (tr >= 0 && !hub_rst[cl] && !l2_rst[cl] && !dbgsoc_rst[cl] && trl < 0) trl = k;
        if (tq >= 0 && !quiesce[cl] && tu < 0) tu = k;
      end
      if (core_start) begin
        nstart++; ts = k;
        chk(tgt_cluster == 1'(cl) && tgt_core == 2'(co), "R7 target", {tgt_cluster, tgt_core}, cl*4+co);
      end
      if (done) begin fc = first_comer; err = done_err; break; end
    end
    @(negedge clk);
    on_after = online;
    chk(busy_bad == 0 && ready, "R8 ready low until done", busy_bad, 0);
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk(online == 8'h01, "R9 online", online, 8'h01);
    chk(pwr_gate == 2'b10, "R9 gate", pwr_gate, 2'b10);
    chk(quiesce == 0 && hub_rst == 0 && l2_rst == 0 && dbgsoc_rst == 0, "R9 cluster lines", {quiesce, hub_rst, l2_rst, dbgsoc_rst}, 0);
    chk(por_hold == 0 && dbg_hold == 0 && trc_hold == 0, "R9 holds", por_hold | dbg_hold | trc_hold, 0);
    chk(l1_rst_dis == 8'hFF && l2_rst_dis == 2'b11, "R9 rstdis", {l1_rst_dis, l2_rst_dis}, 10'h3FF);
    chk(ready && !done && !core_start, "R9 ready", ready, 1);

    // R2: boot core already online
    do_req(0, 0, 0);
    chk(nstart == 0 && err == 0 && tq < 0, "R2 online core no start", nstart, 0);
    // R3: running cluster goes straight to start
    do_req(0, 3, 0);
    chk(fc == 0 && ts == 1 && tq < 0, "R3 running cluster", ts, 1);
    chk(on_after == 8'h09, "R8 mask", on_after, 8'h09);

    for (int lt = 0; lt < 2; lt++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] rest;
        rest = 4'hF & ~(4'h1 << k);
        do_reset();
        do_req(1, k, 1'(lt));
        chk(fc == 1 && err == 0, "R3 first comer", fc, 1);
        chk(tq == 1 && tp == tq + 1 && tr == tp + 1, "R4 order", {tq, tp, tr}, {32'd1, 32'd2, 32'd3});
        chk(trc_at == (lt ? 4'hF : 4'h0), "R4 trace holds", trc_at, lt ? 4'hF : 0);
        chk(td == tr + 1 && tg == td + 1, "R5 order", {td, tg}, {tr + 1, tr + 2});
        chk(l1_at == (lt ? 4'h0 : 4'hF), "R5 L1 lines", l1_at, lt ? 0 : 4'hF);
        chk(trl == tg + W + 1, "R6 settle", trl - tg, W + 1);
        chk(tu == trl + 1, "R6 unquiesce", tu, trl + 1);
        chk(nstart == 1 && ts == tu + 1, "R7 start", ts, tu + 1);
        chk(por_hold[7:4] == rest && dbg_hold[7:4] == rest, "R7 holds handed off", {por_hold[7:4], dbg_hold[7:4]}, {rest, rest});
        chk(trc_hold[7:4] == (lt ? rest : 4'h0), "R7 trace handoff", trc_hold[7:4], lt ? rest : 0);
        chk(pwr_gate == 2'b00 && quiesce == 0 && hub_rst == 0 && l2_rst == 0 && dbgsoc_rst == 0, "R6 final lines", {pwr_gate, quiesce, hub_rst, l2_rst, dbgsoc_rst}, 0);
        chk(on_after == (8'h01 | (8'h10 << k)), "R8 mask", on_after, 8'h01 | (8'h10 << k));
        for (int j = 0; j < 4; j++) begin
          if (j != k) begin
            do_req(1, j, 1'(lt));
            chk(fc == 0 && tq < 0 && ts == 1, "R3 second comer", {fc, ts}, 1);
          end
        end
        do_req(1, k, 1'(lt));
        chk(nstart == 0 && err == 0 && tq < 0, "R2 repeat request", nstart, 0);
        chk(on_after == 8'hF1, "R8 full mask", on_after, 8'hF1);
      end
    end

    // R1 rejected indices
    do_req(2, 0, 0);
    chk(err == 1 && nstart == 0 && on_after == on_before, "R1 cluster 2", err, 1);
    do_req(0, 4, 1);
    chk(err == 1 && nstart == 0 && on_after == on_before, "R1 core 4", err, 1);
    do_req(3, 7, 0);
    chk(err == 1 && nstart == 0 && on_after == on_before && quiesce == 0, "R1 both out", err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule